// File: doc/BRIEF.md
# Dual Masked BCD Alarm Comparator

This block watches a running BCD time of day and calendar and compares it against two independent alarm register sets. Every alarm field register carries a match-enable bit in its top bit and a BCD value below it. Only the fields whose enable is set take part in the comparison. One comparator therefore covers yearly alarms (month, date, hour, minute), weekly alarms (day of week, hour, minute), daily alarms (hour, minute) and any other recurring pattern. An alarm set whose enables are all clear never fires.

The comparison runs once per time-update tick. When an alarm matches on a tick, a sticky per-alarm flag is set. The flag stays set until software clears it through the register port. Each alarm has an interrupt enable. The active-low interrupt output is driven low while any flag whose interrupt enable is set is asserted. The alarm registers, the interrupt enables and the flags are all reached through a simple synchronous write port and a registered read port.

Top module: `dual_alarm_cmp`

## Requirements
- R1: Register map, 4-bit address. For alarm n (n = 0 or 1), field registers sit at address n*8 + k, where k is 0 seconds, 1 minutes, 2 hours, 3 date, 4 month and 5 day of week. Bit 7 of each field register is its enable. The value widths are 7 bits for seconds and minutes, 6 for hours and date, 5 for month and 3 for day of week, and value bits above those widths read back 0. Address 6 holds the interrupt enables (bit 0 alarm 0, bit 1 alarm 1). Address 7 is the flag status in the same bit order. Addresses 14 and 15 read 0. Read data appears on `reg_rdata` one clock after `reg_addr` is presented.
- R2: A synchronous active-high reset clears every alarm register, both interrupt enables and both flags, and drives `irq_n` high.
- R3: An alarm matches when every field whose enable bit is 1 equals the corresponding current time field. Fields whose enable bit is 0 are ignored.
- R4: An alarm whose six enable bits are all 0 never sets its flag, even when its stored values equal the current time.
- R5: A match on a tick sets the alarm's flag on that clock edge. The flag stays set after the time moves past the match, until it is cleared.
- R6: Without `tick`, no change of the current time fields sets a flag.
- R7: Writing address 7 clears each flag whose data bit is 1 and leaves flags with a 0 bit alone. If a tick match and a clear of the same flag fall in the same cycle, the flag ends up set.
- R8: `irq_n` is low exactly when some flag is set together with its interrupt enable. It updates on the same edge as the flags, and one clock after a write to the interrupt enables.
- R9: The two alarms are independent. A match of one alarm never sets the flag of the other.
- R10: Alarm hours are compared against the 24-hour BCD hour (00 to 23). There is no 12/24-hour select, so 0x09 does not match an alarm hour of 0x21.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse marking a time update |
| cur_sec | input | 7 | Current seconds, BCD 00-59 |
| cur_min | input | 7 | Current minutes, BCD 00-59 |
| cur_hour | input | 6 | Current hour, 24-hour BCD 00-23 |
| cur_date | input | 6 | Current date, BCD 01-31 |
| cur_month | input | 5 | Current month, BCD 01-12 |
| cur_dow | input | 3 | Current day of week, 0-6 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| alarm_flag | output | 2 | Sticky alarm flags, bit n for alarm n |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The hardest case to reach is a tick match and a software clear of the same flag in the same cycle. From the ports this needs the write strobe and the tick raised on the same edge. A dedicated bench task drives both together and then checks that the flag survives. A second hard-to-see case is stickiness. A match flag must not be confused with a flag that is merely still set, so the bench walks a table of enable masks and time patterns and clears the flags before every vector. It then moves the time off the match on a later tick and confirms the flag has not dropped.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int N_ALARMS = 2;
  localparam int N_FIELDS = 6;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int VAL_W    = DATA_W - 1;
  localparam int SEC_W    = 7;
  localparam int MIN_W    = 7;
  localparam int HOUR_W   = 6;
  localparam int DATE_W   = 6;
  localparam int MONTH_W  = 5;
  localparam int DOW_W    = 3;
  localparam int ALARM_STRIDE = 8;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(7);

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_DOW   = 3'd5
  } field_e;

  function automatic int field_width(input int idx);
    case (idx)
      0:       return SEC_W;
      1:       return MIN_W;
      2:       return HOUR_W;
      3:       return DATE_W;
      4:       return MONTH_W;
      default: return DOW_W;
    endcase
  endfunction

  function automatic logic [VAL_W-1:0] field_mask(input int idx);
    return VAL_W'((1 << field_width(idx)) - 1);
  endfunction
endpackage

// File: rtl/alarm_cmp_regs.sv
module alarm_cmp_regs
  import alarm_cmp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [N_ALARMS-1:0] flags,
  output logic [DATA_W-1:0]   fld_q [N_ALARMS][N_FIELDS],
  output logic [N_ALARMS-1:0] ie_q,
  output logic [N_ALARMS-1:0] clr_mask,
  output logic [DATA_W-1:0]   rdata
);
  localparam int FIDX_W = $clog2(ALARM_STRIDE);

  // Field storage: one register per field, masked to the field width on write.
  for (genvar a = 0; a < N_ALARMS; a++) begin : g_alarm
    for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(a * ALARM_STRIDE + f);
      localparam logic [DATA_W-1:0] KEEP    = {1'b1, field_mask(f)};
      always_ff @(posedge clk) begin
        if (rst) begin
          fld_q[a][f] <= '0;
        end else if (we && addr == MY_ADDR) begin
          fld_q[a][f] <= wdata & KEEP;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q <= '0;
    end else if (we && addr == CTRL_ADDR) begin
      ie_q <= wdata[N_ALARMS-1:0];
    end
  end

  always_comb begin
    clr_mask = '0;
    if (we && addr == STAT_ADDR) begin
      clr_mask = wdata[N_ALARMS-1:0];
    end
  end

  logic [DATA_W-1:0] rd_next;
  logic [FIDX_W-1:0] fidx;
  logic              asel;

  assign fidx = addr[FIDX_W-1:0];
  assign asel = addr[FIDX_W];

  always_comb begin
    rd_next = '0;
    if (addr == CTRL_ADDR) begin
      rd_next = DATA_W'(ie_q);
    end else if (addr == STAT_ADDR) begin
      rd_next = DATA_W'(flags);
    end else if (32'(fidx) < N_FIELDS) begin
      rd_next = fld_q[asel][fidx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd_next;
    end
  end
endmodule

// File: rtl/alarm_cmp_match.sv
module alarm_cmp_match
  import alarm_cmp_pkg::*;
(
  input  logic [DATA_W-1:0] fld [N_FIELDS],
  input  logic [VAL_W-1:0]  cur [N_FIELDS],
  output logic              hit,
  output logic              any_en
);
  logic [N_FIELDS-1:0] en;
  logic [N_FIELDS-1:0] fhit;

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_cmp
    localparam logic [VAL_W-1:0] MASK = field_mask(f);
    assign en[f]   = fld[f][DATA_W-1];
    assign fhit[f] = !en[f] || ((fld[f][VAL_W-1:0] & MASK) == (cur[f] & MASK));
  end

  assign any_en = |en;
  assign hit    = any_en && (&fhit);
endmodule

// File: rtl/alarm_cmp_status.sv
module alarm_cmp_status
  import alarm_cmp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [N_ALARMS-1:0] hit,
  input  logic [N_ALARMS-1:0] clr,
  input  logic [N_ALARMS-1:0] ie,
  output logic [N_ALARMS-1:0] flag_q,
  output logic                irq_n_q
);
  logic [N_ALARMS-1:0] flag_d;

  // A tick match takes priority over a clear in the same cycle.
  assign flag_d = (flag_q & ~clr) | (tick ? hit : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= '0;
      irq_n_q <= 1'b1;
    end else begin
      flag_q  <= flag_d;
      irq_n_q <= ~|(flag_d & ie);
    end
  end
endmodule

// File: rtl/dual_alarm_cmp.sv
module dual_alarm_cmp
  import alarm_cmp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic [SEC_W-1:0]      cur_sec,
  input  logic [MIN_W-1:0]      cur_min,
  input  logic [HOUR_W-1:0]     cur_hour,
  input  logic [DATE_W-1:0]     cur_date,
  input  logic [MONTH_W-1:0]    cur_month,
  input  logic [DOW_W-1:0]      cur_dow,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic [N_ALARMS-1:0]   alarm_flag,
  output logic                  irq_n
);
  logic [DATA_W-1:0]   fld_q [N_ALARMS][N_FIELDS];
  logic [VAL_W-1:0]    cur   [N_FIELDS];
  logic [N_ALARMS-1:0] ie_q;
  logic [N_ALARMS-1:0] clr_mask;
  logic [N_ALARMS-1:0] hit;
  logic [N_ALARMS-1:0] any_en;

  assign cur[FLD_SEC]   = VAL_W'(cur_sec);
  assign cur[FLD_MIN]   = VAL_W'(cur_min);
  assign cur[FLD_HOUR]  = VAL_W'(cur_hour);
  assign cur[FLD_DATE]  = VAL_W'(cur_date);
  assign cur[FLD_MONTH] = VAL_W'(cur_month);
  assign cur[FLD_DOW]   = VAL_W'(cur_dow);

  alarm_cmp_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .flags    (alarm_flag),
    .fld_q    (fld_q),
    .ie_q     (ie_q),
    .clr_mask (clr_mask),
    .rdata    (reg_rdata)
  );

  for (genvar a = 0; a < N_ALARMS; a++) begin : g_match
    alarm_cmp_match u_match (
      .fld    (fld_q[a]),
      .cur    (cur),
      .hit    (hit[a]),
      .any_en (any_en[a])
    );
  end

  alarm_cmp_status u_status (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .hit     (hit),
    .clr     (clr_mask),
    .ie      (ie_q),
    .flag_q  (alarm_flag),
    .irq_n_q (irq_n)
  );
endmodule

// File: rtl/dual_alarm_cmp_chk.sv
module dual_alarm_cmp_chk
  import alarm_cmp_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic                reg_we,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic [N_ALARMS-1:0] alarm_flag,
  input logic [N_ALARMS-1:0] ie_q,
  input logic [N_ALARMS-1:0] any_en,
  input logic                irq_n
);
  a_r2_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (alarm_flag == '0 && irq_n));

  a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq_n == !(|(alarm_flag & $past(ie_q))));

  for (genvar a = 0; a < N_ALARMS; a++) begin : g_al
    a_r4_no_enable_no_set: assert property (@(posedge clk) disable iff (rst)
      (!any_en[a] && !alarm_flag[a]) |=> !alarm_flag[a]);

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (alarm_flag[a] && !(reg_we && reg_addr == STAT_ADDR && reg_wdata[a]))
      |=> alarm_flag[a]);

    a_r6_set_needs_tick: assert property (@(posedge clk) disable iff (rst)
      (!tick && !alarm_flag[a]) |=> !alarm_flag[a]);

    a_r7_clear_works: assert property (@(posedge clk) disable iff (rst)
      (!tick && reg_we && reg_addr == STAT_ADDR && reg_wdata[a]) |=> !alarm_flag[a]);
  end
endmodule

bind dual_alarm_cmp dual_alarm_cmp_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .alarm_flag (alarm_flag),
  .ie_q       (ie_q),
  .any_en     (any_en),
  .irq_n      (irq_n)
);

// File: tb/dual_alarm_cmp_tb.sv
module dual_alarm_cmp_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [6:0] cur_sec = '0;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic [5:0] cur_date = 6'h01;
  logic [4:0] cur_month = 5'h01;
  logic [2:0] cur_dow = '0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] alarm_flag;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_alarm_cmp u_dut (
    .clk(clk), .rst(rst), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .cur_month(cur_month), .cur_dow(cur_dow),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_flag(alarm_flag), .irq_n(irq_n)
  );

  // Alarm 0 stored values used by the table: 21:30:15, date 14, month 07, dow 3.
  localparam logic [7:0] AV [6] = '{8'h15, 8'h30, 8'h21, 8'h14, 8'h07, 8'h03};

  // {enable mask[5:0] (bit k = field k), sec, min, hour, date, month, dow, expected}
  localparam int NV = 13;
  localparam logic [40:0] VEC [NV] = '{
    {6'b000110, 7'h00, 7'h30, 6'h21, 6'h01, 5'h01, 3'd0, 1'b1},
    {6'b000110, 7'h00, 7'h31, 6'h21, 6'h01, 5'h01, 3'd0, 1'b0},
    {6'b000110, 7'h59, 7'h30, 6'h09, 6'h01, 5'h01, 3'd0, 1'b0},
    {6'b100110, 7'h00, 7'h30, 6'h21, 6'h05, 5'h02, 3'd3, 1'b1},
    {6'b100110, 7'h00, 7'h30, 6'h21, 6'h05, 5'h02, 3'd4, 1'b0},
    {6'b011110, 7'h00, 7'h30, 6'h21, 6'h14, 5'h07, 3'd0, 1'b1},
    {6'b011110, 7'h00, 7'h30, 6'h21, 6'h14, 5'h08, 3'd0, 1'b0},
    {6'b000001, 7'h15, 7'h00, 6'h00, 6'h01, 5'h01, 3'd0, 1'b1},
    {6'b111111, 7'h15, 7'h30, 6'h21, 6'h14, 5'h07, 3'd3, 1'b1},
    {6'b111111, 7'h16, 7'h30, 6'h21, 6'h14, 5'h07, 3'd3, 1'b0},
    {6'b000000, 7'h15, 7'h30, 6'h21, 6'h14, 5'h07, 3'd3, 1'b0},
    {6'b001000, 7'h00, 7'h00, 6'h00, 6'h14, 5'h01, 3'd6, 1'b1},
    {6'b000100, 7'h00, 7'h30, 6'h20, 6'h14, 5'h07, 3'd3, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    check(req, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic set_time(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                          input logic [5:0] d, input logic [4:0] mo, input logic [2:0] w);
    cur_sec = s; cur_min = m; cur_hour = h; cur_date = d; cur_month = mo; cur_dow = w;
  endtask

  task automatic do_tick(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                         input logic [5:0] d, input logic [4:0] mo, input logic [2:0] w);
    @(negedge clk);
    set_time(s, m, h, d, mo, w);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: reset state
    check("R2 flags", 32'(alarm_flag), 32'h0);
    check("R2 irq_n", 32'(irq_n), 32'h1);
    rd_check("R2 alarm0 sec", 4'h0, 8'h00);
    rd_check("R2 alarm1 dow", 4'hD, 8'h00);
    rd_check("R2 ie", 4'h6, 8'h00);

    // R1: readback with width masking
    wr(4'h8, 8'hFF); rd_check("R1 sec mask", 4'h8, 8'hFF);
    wr(4'hA, 8'hFF); rd_check("R1 hour mask", 4'hA, 8'hBF);
    wr(4'hC, 8'hFF); rd_check("R1 month mask", 4'hC, 8'h9F);
    wr(4'hD, 8'hFF); rd_check("R1 dow mask", 4'hD, 8'h87);
    wr(4'hE, 8'hFF); rd_check("R1 unused addr", 4'hE, 8'h00);
    wr(4'h8, 8'h00); wr(4'hA, 8'h00); wr(4'hC, 8'h00); wr(4'hD, 8'h00);

    // R3, R4, R10: table walk on alarm 0
    for (int i = 0; i < NV; i++) begin
      for (int f = 0; f < 6; f++) begin
        wr(4'(f), {VEC[i][35 + f], AV[f][6:0]});
      end
      wr(4'h7, 8'h03);
      do_tick(VEC[i][34:28], VEC[i][27:21], VEC[i][20:15], VEC[i][14:9],
              VEC[i][8:4], VEC[i][3:1]);
      check($sformatf("R3/R4/R10 vector %0d flag0", i), 32'(alarm_flag[0]), 32'(VEC[i][0]));
      check($sformatf("R9 vector %0d flag1", i), 32'(alarm_flag[1]), 32'h0);
    end

    // Daily 21:30 on alarm 0
    for (int f = 0; f < 6; f++) wr(4'(f), (f == 1 || f == 2) ? {1'b1, AV[f][6:0]} : 8'h00);
    wr(4'h7, 8'h03);
    // R6: matching time without tick
    @(negedge clk); set_time(7'h00, 7'h30, 6'h21, 6'h01, 5'h01, 3'd0);
    repeat (2) @(negedge clk);
    check("R6 no tick", 32'(alarm_flag), 32'h0);
    // R5: set then sticky
    do_tick(7'h00, 7'h30, 6'h21, 6'h01, 5'h01, 3'd0);
    check("R5 set", 32'(alarm_flag), 32'h1);
    do_tick(7'h00, 7'h31, 6'h21, 6'h01, 5'h01, 3'd0);
    check("R5 sticky", 32'(alarm_flag), 32'h1);
    rd_check("R5 status read", 4'h7, 8'h01);
    // R7: clear semantics
    wr(4'h7, 8'h00); check("R7 zero write keeps", 32'(alarm_flag), 32'h1);
    wr(4'h7, 8'h02); check("R7 other bit keeps", 32'(alarm_flag), 32'h1);
    wr(4'h7, 8'h01); check("R7 cleared", 32'(alarm_flag), 32'h0);
    @(negedge clk);
    set_time(7'h00, 7'h30, 6'h21, 6'h01, 5'h01, 3'd0);
    tick = 1'b1; reg_we = 1'b1; reg_addr = 4'h7; reg_wdata = 8'h01;
    @(negedge clk);
    tick = 1'b0; reg_we = 1'b0;
    check("R7 set beats clear", 32'(alarm_flag), 32'h1);
    // R8: interrupt
    check("R8 irq masked", 32'(irq_n), 32'h1);
    wr(4'h6, 8'h01);
    @(negedge clk);
    check("R8 irq asserted", 32'(irq_n), 32'h0);
    rd_check("R8 ie read", 4'h6, 8'h01);
    wr(4'h7, 8'h01);
    check("R8 irq released", 32'(irq_n), 32'h1);

    // R9: independence with alarm 1 on minute 45
    wr(4'h9, 8'hC5);
    wr(4'h6, 8'h03);
    do_tick(7'h00, 7'h30, 6'h21, 6'h01, 5'h01, 3'd0);
    check("R9 only alarm0", 32'(alarm_flag), 32'h1);
    do_tick(7'h00, 7'h45, 6'h10, 6'h01, 5'h01, 3'd0);
    check("R9 both", 32'(alarm_flag), 32'h3);
    check("R8 irq both", 32'(irq_n), 32'h0);
    wr(4'h7, 8'h01);
    check("R9 clear alarm0 only", 32'(alarm_flag), 32'h2);
    check("R8 irq from alarm1", 32'(irq_n), 32'h0);
    wr(4'h7, 8'h02);
    check("R8 irq idle", 32'(irq_n), 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule